// File: doc/BRIEF.md
# Configurable Byte-Order Data Access Unit

This unit sits between a small processor core and a byte-addressed memory that is 32 bits wide. For every data load or store it places bytes on the correct memory lanes and builds the write byte-enables. It also assembles load results, with zero or sign extension for narrow accesses. The byte order is normally taken from a global mode bit. A table of four address regions can override that bit, and a region may also select a mixed order. In the mixed order a 32-bit value is kept as two little-endian 16-bit halves, with the more significant half at the lower address.

Instruction fetches never use the steering logic. The fetch address and the fetched word pass straight through, so instruction words and the immediates inside them stay little-endian whatever data order is active.

The data request side follows a valid/ready handshake. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` follows `mem_ready`, so the memory stalls the core through this unit. While a request is stalled, the core must hold it and its fields steady. A misaligned request is accepted at once: it raises `fault` and never reaches memory. Load data is valid in the cycle of acceptance, and `rsp_valid` marks that cycle.

Top module: `endian_lsu`

## Requirements
- R1: With no region matching, global bit 0 selects little-endian and 1 selects big-endian for data: a word 0x1234ABCD stored little-endian and read back big-endian returns 0xCDAB3412.
- R2: After reset the global bit is 0, so a word store lands little-endian (0x0A0B0C0D at offset 0 gives lanes 0D,0C,0B,0A), and no request or fault is driven.
- R3: A global-bit write (`cfg_glb_we`) or a region write (`rgn_we`) takes effect only when `cfg_priv` is 1. Without it the global bit is left unchanged.
- R4: `if_mem_addr` always equals `if_addr` and `if_data` always equals `if_mem_rdata`, independent of any byte-order setting.
- R5: An enabled region whose inclusive range base..limit contains the address sets the order and overrides the global bit. Region order codes are 0 = little, 1 = big, 2 = mixed. A disabled entry is never used.
- R6: In mixed order, word 0x1234ABCD occupies ascending byte addresses as 34,12,CD,AB, and a mixed-order word load inverts that layout.
- R7: In mixed order a halfword is little-endian: 0xABCD at offset 2 is stored as CD then AB.
- R8: Size code 0 = byte, 1 = halfword, 2 = word. Byte and halfword loads are zero-extended when `req_signed` is 0 and sign-extended when it is 1.
- R9: A halfword at an odd address, a word not at a multiple of 4, or size code 3 raises `fault`, keeps `mem_valid` low and writes nothing.
- R10: Store byte-enables cover exactly the written lanes: one lane for a byte (lane = address bits 1:0), lanes 0–1 or 2–3 for a halfword, all four for a word.
- R11: When several enabled regions match, the lowest-numbered entry decides the order.
- R12: While `mem_ready` is 0, an aligned request is not accepted (`req_ready` = 0) and no write completes. The write completes on the first cycle `mem_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_priv | input | 1 | Writer is in privileged mode |
| cfg_glb_we | input | 1 | Write strobe for the global order bit |
| cfg_glb_val | input | 1 | New global order (0 little, 1 big) |
| rgn_we | input | 1 | Write strobe for one region entry |
| rgn_idx | input | 2 | Region entry index |
| rgn_base | input | 32 | Region lowest address |
| rgn_limit | input | 32 | Region highest address (inclusive) |
| rgn_en | input | 1 | Region enable |
| rgn_ord | input | 2 | Region order code |
| req_valid | input | 1 | Data request valid |
| req_ready | output | 1 | Data request accepted |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store value, right-aligned |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 32 | Load result |
| fault | output | 1 | Alignment fault for the current request |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Memory read word |
| if_addr | input | 32 | Fetch address from core |
| if_mem_addr | output | 32 | Fetch address to memory |
| if_mem_rdata | input | 32 | Fetched word from memory |
| if_data | output | 32 | Fetched word to core |

## Verification
The assertions check several rules on every cycle. A faulting request never reaches memory, and the byte-enable count matches the access size on every issued store. A global-bit write from user mode leaves the bit unchanged, and the bit is clear just after reset. A region hit always points at an enabled entry whose range contains the address, and a stalled request stays steady. The actual byte layouts can only be shown by the bench's scenarios: little, big and mixed order, the overrides, region priority, sign extension, the fetch pass-through and the back-pressure timing. The bench shows them by storing through the unit and inspecting memory words, and by reading values back under a different order.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {ORD_LE = 2'd0, ORD_BE = 2'd1, ORD_MID = 2'd2} order_e;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;

  function automatic logic [15:0] swap2(input logic [15:0] h);
    return {h[7:0], h[15:8]};
  endfunction

  function automatic logic [31:0] swap4(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // mixed order: halves exchanged, each half little-endian; self-inverse
  function automatic logic [31:0] swap_halves(input logic [31:0] w);
    return {w[15:0], w[31:16]};
  endfunction
endpackage

// File: rtl/lsu_order_ctrl.sv
module lsu_order_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic priv_i,
  input  logic we_i,
  input  logic val_i,
  output logic glb_be_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)              glb_be_o <= 1'b0;
    else if (we_i && priv_i) glb_be_o <= val_i;
  end

  p_user_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !priv_i) |=> $stable(glb_be_o));

  p_reset_le_r2: assert property (@(posedge clk)
    $rose(rst_n) |-> !glb_be_o);
endmodule

// File: rtl/lsu_region_tbl.sv
module lsu_region_tbl
  import lsu_pkg::*;
#(
  parameter int AW    = 32,
  parameter int N_RGN = 4,
  localparam int IW   = (N_RGN > 1) ? $clog2(N_RGN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          priv_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  input  logic          en_i,
  input  logic [1:0]    ord_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output order_e        ord_o
);
  logic [AW-1:0] base_q  [N_RGN];
  logic [AW-1:0] limit_q [N_RGN];
  logic          en_q    [N_RGN];
  order_e        ord_q   [N_RGN];
  logic [N_RGN-1:0] match;
  logic [IW-1:0] sel;

  for (genvar g = 0; g < N_RGN; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        en_q[g]    <= 1'b0;
        ord_q[g]   <= ORD_LE;
      end else if (we_i && priv_i && idx_i == IW'(g)) begin
        base_q[g]  <= base_i;
        limit_q[g] <= limit_i;
        en_q[g]    <= en_i;
        ord_q[g]   <= order_e'(ord_i);
      end
    end
    assign match[g] = en_q[g] && (addr_i >= base_q[g]) && (addr_i <= limit_q[g]);
  end

  // lowest-numbered match wins: scan downward so the last hit kept is the lowest
  always_comb begin
    hit_o = 1'b0;
    sel   = '0;
    for (int i = N_RGN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        sel   = IW'(i);
      end
    end
    ord_o = ord_q[sel];
  end

  p_hit_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (en_q[sel] && addr_i >= base_q[sel] && addr_i <= limit_q[sel]));
endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
  import lsu_pkg::*;
(
  input  order_e      ord_i,
  input  logic [1:0]  size_i,
  input  logic [1:0]  off_i,
  input  logic        sgn_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] rdata_i,
  output logic [31:0] mem_wdata_o,
  output logic [3:0]  be_o,
  output logic [31:0] ld_data_o,
  output logic        misal_o
);
  localparam int LANES = 4;

  logic [15:0] h_st, h_raw, h_ld;
  logic [31:0] w_st, w_ld;
  logic [7:0]  b_ld;

  always_comb begin
    h_st = (ord_i == ORD_BE) ? swap2(wdata_i[15:0]) : wdata_i[15:0];
    unique case (ord_i)
      ORD_BE:  w_st = swap4(wdata_i);
      ORD_MID: w_st = swap_halves(wdata_i);
      default: w_st = wdata_i;
    endcase
  end

  always_comb begin
    mem_wdata_o = '0;
    be_o        = '0;
    misal_o     = 1'b0;
    case (size_i)
      SZ_BYTE: begin
        mem_wdata_o = {LANES{wdata_i[7:0]}};
        be_o        = 4'b0001 << off_i;
      end
      SZ_HALF: begin
        mem_wdata_o = {2{h_st}};
        be_o        = off_i[1] ? 4'b1100 : 4'b0011;
        misal_o     = off_i[0];
      end
      SZ_WORD: begin
        mem_wdata_o = w_st;
        be_o        = 4'b1111;
        misal_o     = (off_i != 2'b00);
      end
      default: misal_o = 1'b1;
    endcase
  end

  always_comb begin
    b_ld  = rdata_i[{off_i, 3'b000} +: 8];
    h_raw = off_i[1] ? rdata_i[31:16] : rdata_i[15:0];
    h_ld  = (ord_i == ORD_BE) ? swap2(h_raw) : h_raw;
    unique case (ord_i)
      ORD_BE:  w_ld = swap4(rdata_i);
      ORD_MID: w_ld = swap_halves(rdata_i);
      default: w_ld = rdata_i;
    endcase
    case (size_i)
      SZ_BYTE: ld_data_o = {{24{sgn_i & b_ld[7]}}, b_ld};
      SZ_HALF: ld_data_o = {{16{sgn_i & h_ld[15]}}, h_ld};
      default: ld_data_o = w_ld;
    endcase
  end
endmodule

// File: rtl/endian_lsu.sv
module endian_lsu
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_RGN  = 4,
  localparam int IW    = (N_RGN > 1) ? $clog2(N_RGN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_priv,
  input  logic              cfg_glb_we,
  input  logic              cfg_glb_val,
  input  logic              rgn_we,
  input  logic [IW-1:0]     rgn_idx,
  input  logic [ADDR_W-1:0] rgn_base,
  input  logic [ADDR_W-1:0] rgn_limit,
  input  logic              rgn_en,
  input  logic [1:0]        rgn_ord,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              fault,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic [ADDR_W-1:0] if_addr,
  output logic [ADDR_W-1:0] if_mem_addr,
  input  logic [31:0]       if_mem_rdata,
  output logic [31:0]       if_data
);
  logic   glb_be, rgn_hit, misal;
  order_e rgn_o, ord_sel;
  logic [3:0] be_raw;

  lsu_order_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .priv_i(cfg_priv), .we_i(cfg_glb_we),
    .val_i(cfg_glb_val), .glb_be_o(glb_be)
  );

  lsu_region_tbl #(.AW(ADDR_W), .N_RGN(N_RGN)) u_rgn (
    .clk(clk), .rst_n(rst_n), .priv_i(cfg_priv), .we_i(rgn_we), .idx_i(rgn_idx),
    .base_i(rgn_base), .limit_i(rgn_limit), .en_i(rgn_en), .ord_i(rgn_ord),
    .addr_i(req_addr), .hit_o(rgn_hit), .ord_o(rgn_o)
  );

  assign ord_sel = rgn_hit ? rgn_o : (glb_be ? ORD_BE : ORD_LE);

  lsu_lane_steer u_steer (
    .ord_i(ord_sel), .size_i(req_size), .off_i(req_addr[1:0]), .sgn_i(req_signed),
    .wdata_i(req_wdata), .rdata_i(mem_rdata), .mem_wdata_o(mem_wdata),
    .be_o(be_raw), .ld_data_o(rsp_data), .misal_o(misal)
  );

  assign fault     = req_valid && misal;
  assign mem_valid = req_valid && !misal;
  assign req_ready = misal || mem_ready;
  assign mem_write = req_write;
  assign mem_addr  = {req_addr[ADDR_W-1:2], 2'b00};
  assign mem_be    = req_write ? be_raw : 4'b0000;
  assign rsp_valid = mem_valid && mem_ready && !req_write;

  // fetch path bypasses all steering
  assign if_mem_addr = if_addr;
  assign if_data     = if_mem_rdata;

  p_fault_no_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !mem_valid);
  p_be_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && req_size == SZ_WORD) |-> mem_be == 4'b1111);
  p_be_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && req_size == SZ_HALF) |-> $countones(mem_be) == 2);
  p_be_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && req_size == SZ_BYTE) |-> $countones(mem_be) == 1);
  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_wdata)));
endmodule

// File: tb/endian_lsu_tb_top.sv
module endian_lsu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cfg_priv = 0, cfg_glb_we = 0, cfg_glb_val = 0;
  logic rgn_we = 0, rgn_en = 0;
  logic [1:0] rgn_idx = 0, rgn_ord = 0;
  logic [31:0] rgn_base = 0, rgn_limit = 0;
  logic req_valid = 0, req_write = 0, req_signed = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rsp_valid, fault, mem_valid, mem_write;
  logic [31:0] rsp_data, mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic mem_ready = 1;
  logic [31:0] if_addr = 0, if_mem_rdata = 0, if_mem_addr, if_data;

  int checks = 0, errors = 0;
  logic [31:0] mem [16];

  endian_lsu dut_i (.*);

  assign mem_rdata = mem[mem_addr[5:2]];
  always @(posedge clk)
    if (mem_valid && mem_ready && mem_write)
      for (int k = 0; k < 4; k++)
        if (mem_be[k]) mem[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic set_glb(input logic priv, input logic v);
    @(negedge clk); cfg_priv = priv; cfg_glb_we = 1; cfg_glb_val = v;
    @(negedge clk); cfg_glb_we = 0; cfg_priv = 0;
  endtask

  task automatic set_rgn(input int i, input logic [31:0] b, input logic [31:0] l,
                         input logic e, input logic [1:0] o);
    @(negedge clk); cfg_priv = 1; rgn_we = 1; rgn_idx = 2'(i);
    rgn_base = b; rgn_limit = l; rgn_en = e; rgn_ord = o;
    @(negedge clk); rgn_we = 0; cfg_priv = 0;
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic sg,
                        input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic flt);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    rd = rsp_data; flt = fault;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  typedef struct packed {
    logic        glb;
    logic        wr;
    logic [1:0]  sz;
    logic        sg;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
    logic        flt;
    logic [7:0]  rq;
  } vec_t;

  // for stores exp is the memory word afterwards; for loads the returned value
  localparam vec_t VEC [16] = '{
    '{1'b0, 1'b1, 2'd2, 1'b0, 8'h00, 32'h1234ABCD, 32'h1234ABCD, 1'b0, 8'd1},  // R1
    '{1'b0, 1'b0, 2'd2, 1'b0, 8'h00, 32'h0,        32'h1234ABCD, 1'b0, 8'd1},  // R1
    '{1'b1, 1'b0, 2'd2, 1'b0, 8'h00, 32'h0,        32'hCDAB3412, 1'b0, 8'd1},  // R1
    '{1'b1, 1'b1, 2'd1, 1'b0, 8'h06, 32'h0000BEEF, 32'hEFBE0000, 1'b0, 8'd10}, // R10
    '{1'b1, 1'b0, 2'd1, 1'b1, 8'h06, 32'h0,        32'hFFFFBEEF, 1'b0, 8'd8},  // R8
    '{1'b0, 1'b0, 2'd1, 1'b0, 8'h06, 32'h0,        32'h0000EFBE, 1'b0, 8'd8},  // R8
    '{1'b0, 1'b0, 2'd0, 1'b1, 8'h07, 32'h0,        32'hFFFFFFEF, 1'b0, 8'd8},  // R8
    '{1'b0, 1'b0, 2'd0, 1'b0, 8'h03, 32'h0,        32'h00000012, 1'b0, 8'd8},  // R8
    '{1'b0, 1'b1, 2'd2, 1'b0, 8'h20, 32'h1234ABCD, 32'hABCD1234, 1'b0, 8'd6},  // R6
    '{1'b1, 1'b0, 2'd2, 1'b0, 8'h20, 32'h0,        32'h1234ABCD, 1'b0, 8'd5},  // R5 R6
    '{1'b0, 1'b1, 2'd1, 1'b0, 8'h26, 32'h0000ABCD, 32'hABCD0000, 1'b0, 8'd7},  // R7
    '{1'b0, 1'b1, 2'd2, 1'b0, 8'h30, 32'h11223344, 32'h44332211, 1'b0, 8'd5},  // R5
    '{1'b0, 1'b1, 2'd1, 1'b0, 8'h34, 32'h00005566, 32'h00006655, 1'b0, 8'd11}, // R11
    '{1'b1, 1'b1, 2'd1, 1'b0, 8'h28, 32'h00005566, 32'h00005566, 1'b0, 8'd5},  // R5
    '{1'b0, 1'b1, 2'd1, 1'b0, 8'h01, 32'h0000FFFF, 32'h1234ABCD, 1'b1, 8'd9},  // R9
    '{1'b0, 1'b0, 2'd2, 1'b0, 8'h22, 32'h0,        32'h0,        1'b1, 8'd9}   // R9
  };

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic flt;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R2: idle outputs and little-endian default
    chk("R2 idle mem_valid", {31'd0, mem_valid}, 32'd0);
    chk("R2 idle fault", {31'd0, fault}, 32'd0);
    access(1, 2'd2, 0, 32'h08, 32'h0A0B0C0D, rd, flt);
    chk("R2 reset order", mem[2], 32'h0A0B0C0D);

    // R3: user-mode write rejected
    set_glb(0, 1);
    access(1, 2'd2, 0, 32'h0C, 32'h01020304, rd, flt);
    chk("R3 user write ignored", mem[3], 32'h01020304);

    // regions: 0 mixed, 1 big, 2 little (overlaps 1), 3 disabled big over all
    set_rgn(0, 32'h20, 32'h27, 1, 2'd2);
    set_rgn(1, 32'h30, 32'h3F, 1, 2'd1);
    set_rgn(2, 32'h28, 32'h3F, 1, 2'd0);
    set_rgn(3, 32'h00, 32'hFF, 0, 2'd1);

    for (int v = 0; v < 16; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[v].rq, v);
      set_glb(1, VEC[v].glb);
      access(VEC[v].wr, VEC[v].sz, VEC[v].sg, {24'd0, VEC[v].a}, VEC[v].d, rd, flt);
      chk({tag, " fault"}, {31'd0, flt}, {31'd0, VEC[v].flt});
      if (VEC[v].wr) chk(tag, mem[VEC[v].a[5:2]], VEC[v].exp);
      else if (!VEC[v].flt) chk(tag, rd, VEC[v].exp);
    end

    // R4: fetch path untouched under big-endian data mode
    set_glb(1, 1);
    @(negedge clk); if_addr = 32'h0000_0123; if_mem_rdata = 32'hDEADBEEF; #1;
    chk("R4 fetch addr", if_mem_addr, 32'h0000_0123);
    chk("R4 fetch data", if_data, 32'hDEADBEEF);

    // R10: byte store lane enable at offset 2
    set_glb(1, 0);
    @(negedge clk); req_valid = 1; req_write = 1; req_size = 2'd0;
    req_addr = 32'h1E; req_wdata = 32'h000000C3; #1;
    chk("R10 byte enable", {28'd0, mem_be}, 32'h4);
    chk("R10 no rsp on store", {31'd0, rsp_valid}, 32'd0);
    @(posedge clk); #1; req_valid = 0;
    chk("R10 byte lane", mem[7], 32'h00C30000);

    // R12: back-pressure holds the store
    @(negedge clk); mem_ready = 0; req_valid = 1; req_write = 1; req_size = 2'd2;
    req_addr = 32'h10; req_wdata = 32'h55AA1177;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 stalled ready", {31'd0, req_ready}, 32'd0);
    chk("R12 no write while stalled", mem[4], 32'h0);
    mem_ready = 1;
    @(posedge clk); #1; req_valid = 0;
    chk("R12 write after release", mem[4], 32'h55AA1177);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule